// File: doc/BRIEF.md
# Write Request Qualifier with Strobe Filter and Supply Lockout

This block sits in front of a non-volatile memory programming controller and decides whether a write request may reach it. It watches three active-low control strobes (chip select, write strobe, output drive), which arrive already sampled into the clock domain. It also watches a digital supply-good flag from an external voltage comparator. It produces a one-cycle write-start pulse for each write strobe that it accepts.

A strobe is accepted only under four conditions. The supply must have been good for long enough. The write command must have been held for a minimum number of clock cycles. The strobe must end cleanly, with the output drive still off. The supply must have stayed usable for the whole strobe. After the supply flag rises, a short debounce comes first, and a power-up hold-off period follows it. Losing the flag at any point restarts that sequence from zero. A lockout status flag shows whether the supply side currently allows writes.

Top module: `wpq_write_qualifier`

## Requirements
- R1: While reset is applied and after its release, `wr_start` is 0 and `inhibit` is 1 until the supply sequence of R2 and R3 completes.
- R2: The supply flag counts as stable only after DEB_CYC consecutive clock samples of `vdd_ok`=1. A single sample of 0 restarts that count.
- R3: After `vdd_ok` has been sampled 1 for DEB_CYC+HOLD_CYC consecutive cycles, the lockout ends. `inhibit` falls right after that sample. No write starts while the lockout holds.
- R4: A sample of `vdd_ok`=0 raises `inhibit` after that edge. It also restarts both the debounce and the hold-off from zero.
- R5: A write command is a sample with `ce_n`=0, `we_n`=0 and `oe_n`=1. Any other combination issues no write.
- R6: A write command held for fewer than MIN_LOW_CYC consecutive samples produces no pulse. Exactly MIN_LOW_CYC samples is enough.
- R7: An accepted strobe gives a single one-cycle `wr_start` pulse. The pulse is visible in the cycle after the first sample in which `ce_n` or `we_n` is 1, with `oe_n`=1. Either strobe may end the command.
- R8: If `oe_n` is 0 in the first sample after the command ends, the strobe is discarded and no pulse follows.
- R9: If the supply lockout is active in any sample of the strobe, or in its ending sample, no pulse follows.
- R10: `inhibit` reports the supply lockout only. It is 1 exactly when R3 has not been met since the last 0 sample of `vdd_ok` or the last reset.
- R11: A command held far longer than MIN_LOW_CYC still yields exactly one pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asserted asynchronously |
| ce_n | input | 1 | Chip select, active low, sampled |
| we_n | input | 1 | Write strobe, active low, sampled |
| oe_n | input | 1 | Output drive enable, active low, sampled |
| vdd_ok | input | 1 | Supply-good flag from the external comparator |
| wr_start | output | 1 | One-cycle pulse that starts a programming cycle |
| inhibit | output | 1 | 1 while the supply lockout blocks writes |

## Verification
The assertions assume that the three strobes and the supply flag are already synchronous to `clk`. They also assume that every count parameter is at least 1, so that each counter has a reachable terminal value. The stimulus changes inputs only just after a rising edge and holds them for whole cycles, so every strobe length is an exact number of samples. It leaves all strobes idle and the supply low while reset is being released. This covers the synchronizer cycles in which the block is still held.

// File: rtl/wpq_pkg.sv
package wpq_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_LOW  = 1'b1
  } stb_state_e;

  // A write command needs select and write strobe active with output drive off.
  function automatic logic is_write_cmd(input logic ce_n, input logic we_n,
                                        input logic oe_n);
    return (!ce_n) && (!we_n) && oe_n;
  endfunction

endpackage

// File: rtl/wpq_rst_sync.sv
module wpq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= 1'b1;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/wpq_supply_debounce.sv
module wpq_supply_debounce #(
  parameter int unsigned DEB_CYC = 4
) (
  input  logic clk,
  input  logic srst_n,
  input  logic vdd_ok_i,
  output logic stable_o
);

  localparam int unsigned CW = $clog2(DEB_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(DEB_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!vdd_ok_i)             cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign stable_o = (cnt_q == CNT_MAX);

  // R2: one low sample drops stability right after the edge.
  a_r2_low_clears: assert property (@(posedge clk) disable iff (!srst_n)
    !vdd_ok_i |=> !stable_o);

  // R2: stability can only appear after a high sample.
  a_r2_rise_needs_high: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(stable_o) |-> $past(vdd_ok_i));

endmodule

// File: rtl/wpq_holdoff_timer.sv
module wpq_holdoff_timer #(
  parameter int unsigned HOLD_CYC = 200
) (
  input  logic clk,
  input  logic srst_n,
  input  logic stable_i,
  output logic ready_o
);

  localparam int unsigned CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!stable_i)             cnt_d = '0;
    else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign ready_o = (cnt_q == CNT_MAX) && stable_i;

  // R4: losing stability restarts the hold-off, so no readiness next cycle.
  a_r4_restart: assert property (@(posedge clk) disable iff (!srst_n)
    !stable_i |=> !ready_o);

  // R3: readiness only arrives after a stable sample.
  a_r3_rise_after_stable: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(ready_o) |-> $past(stable_i));

endmodule

// File: rtl/wpq_strobe_filter.sv
module wpq_strobe_filter
  import wpq_pkg::*;
#(
  parameter int unsigned MIN_LOW_CYC = 3
) (
  input  logic clk,
  input  logic srst_n,
  input  logic ce_n_i,
  input  logic we_n_i,
  input  logic oe_n_i,
  input  logic ready_i,
  output logic wr_start_o
);

  localparam int unsigned CW = $clog2(MIN_LOW_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_LOW_CYC);

  stb_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          spoil_q, spoil_d;
  logic          start_q, start_d;
  logic          wr_cmd;
  logic          released;

  always_comb begin
    wr_cmd   = is_write_cmd(ce_n_i, we_n_i, oe_n_i);
    released = (state_q == ST_LOW) && !wr_cmd;
    start_d  = released && oe_n_i && (cnt_q == CNT_MAX) && !spoil_q && ready_i;

    state_d = ST_IDLE;
    cnt_d   = '0;
    spoil_d = 1'b0;
    if (wr_cmd) begin
      state_d = ST_LOW;
      if (state_q == ST_LOW) begin
        cnt_d   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
        spoil_d = spoil_q || !ready_i;
      end else begin
        cnt_d   = CW'(1);
        spoil_d = !ready_i;
      end
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      spoil_q <= 1'b0;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      spoil_q <= spoil_d;
      start_q <= start_d;
    end
  end

  assign wr_start_o = start_q;

  // R7: the start pulse lasts a single cycle.
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!srst_n)
    start_q |=> !start_q);

  // R7 / R8: a pulse follows a clean ending sample.
  a_r8_clean_end: assert property (@(posedge clk) disable iff (!srst_n)
    start_q |-> ($past(oe_n_i) && ($past(ce_n_i) || $past(we_n_i))));

  // R9: no pulse when the lockout was active at the ending sample.
  a_r9_ready_at_end: assert property (@(posedge clk) disable iff (!srst_n)
    start_q |-> $past(ready_i));

  // R6: a pulse needs a strobe in progress before the ending sample.
  a_r6_strobe_seen: assert property (@(posedge clk) disable iff (!srst_n)
    start_q |-> $past(state_q == ST_LOW));

endmodule

// File: rtl/wpq_write_qualifier.sv
module wpq_write_qualifier #(
  parameter int unsigned DEB_CYC     = 4,
  parameter int unsigned HOLD_CYC    = 200,
  parameter int unsigned MIN_LOW_CYC = 3,
  parameter int unsigned RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  input  logic vdd_ok,
  output logic wr_start,
  output logic inhibit
);

  logic srst_n;
  logic sup_stable;
  logic sup_ready;

  wpq_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  wpq_supply_debounce #(.DEB_CYC(DEB_CYC)) u_debounce (
    .clk      (clk),
    .srst_n   (srst_n),
    .vdd_ok_i (vdd_ok),
    .stable_o (sup_stable)
  );

  wpq_holdoff_timer #(.HOLD_CYC(HOLD_CYC)) u_holdoff (
    .clk      (clk),
    .srst_n   (srst_n),
    .stable_i (sup_stable),
    .ready_o  (sup_ready)
  );

  wpq_strobe_filter #(.MIN_LOW_CYC(MIN_LOW_CYC)) u_filter (
    .clk        (clk),
    .srst_n     (srst_n),
    .ce_n_i     (ce_n),
    .we_n_i     (we_n),
    .oe_n_i     (oe_n),
    .ready_i    (sup_ready),
    .wr_start_o (wr_start)
  );

  assign inhibit = !sup_ready;

  // R10: a low supply sample always shows as lockout in the next cycle.
  a_r10_low_locks: assert property (@(posedge clk) disable iff (!srst_n)
    !vdd_ok |=> inhibit);

  // R3: no write starts while the lockout was in force.
  a_r3_no_start_locked: assert property (@(posedge clk) disable iff (!srst_n)
    wr_start |-> !$past(inhibit));

endmodule

// File: tb/wpq_write_qualifier_tb_top.sv
module wpq_write_qualifier_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEB  = 4;
  localparam int HOLD = 200;
  localparam int MINL = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1;
  logic we_n = 1'b1;
  logic oe_n = 1'b1;
  logic vdd_ok = 1'b0;
  logic wr_start;
  logic inhibit;

  always #(CLK_PERIOD/2) clk = ~clk;

  wpq_write_qualifier #(
    .DEB_CYC(DEB), .HOLD_CYC(HOLD), .MIN_LOW_CYC(MINL), .RST_STAGES(2)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .vdd_ok(vdd_ok), .wr_start(wr_start), .inhibit(inhibit)
  );

  int    compared = 0;
  int    mismatched = 0;
  int    pulses = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Behavioural reference: consecutive good samples and strobe bookkeeping.
  int run = 0;
  bit m_act = 0;
  int m_len = 0;
  bit m_bad = 0;
  bit exp_wr = 0;
  bit exp_ready = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run = 0; m_act = 0; m_len = 0; m_bad = 0; exp_wr = 0; exp_ready = 0;
    end else begin
      bit rdy;
      bit cmd;
      rdy = (run >= DEB + HOLD);
      cmd = (ce_n == 1'b0) && (we_n == 1'b0) && (oe_n == 1'b1);
      exp_wr = m_act && !cmd && oe_n && (m_len >= MINL) && !m_bad && rdy;
      if (cmd) begin
        m_bad = m_act ? (m_bad || !rdy) : !rdy;
        m_len = m_act ? m_len + 1 : 1;
        m_act = 1;
      end else begin
        m_act = 0; m_len = 0; m_bad = 0;
      end
      run = vdd_ok ? run + 1 : 0;
      exp_ready = (run >= DEB + HOLD);
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      compared += 2;
      if (wr_start !== exp_wr) begin
        mismatched++;
        $display("FAIL %s wr_start actual=%0b expected=%0b at %0t", cur_req, wr_start, exp_wr, $time);
      end
      if (inhibit !== !exp_ready) begin
        mismatched++;
        $display("FAIL %s inhibit actual=%0b expected=%0b at %0t", cur_req, inhibit, !exp_ready, $time);
      end
      if (wr_start === 1'b1) pulses++;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic strobe(input int len, input bit via_ce);
    ce_n = 1'b0; we_n = 1'b0;
    tick(len);
    if (via_ce) ce_n = 1'b1; else we_n = 1'b1;
    tick(1);
    ce_n = 1'b1; we_n = 1'b1;
    tick(3);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    mismatched++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int base;
    // R1: reset state
    tick(4);
    check("R1", "wr_start in reset", int'(wr_start), 0);
    check("R1", "inhibit in reset", int'(inhibit), 1);
    rst_n = 1'b1;
    tick(4);
    check("R1", "inhibit after release", int'(inhibit), 1);

    // R9: strobe with supply absent
    cur_req = "R9"; base = pulses;
    strobe(6, 1'b0);
    check("R9", "pulses with supply low", pulses - base, 0);

    // R2: glitch in the supply flag restarts debounce
    cur_req = "R2";
    vdd_ok = 1'b1; tick(DEB - 1);
    vdd_ok = 1'b0; tick(1);
    vdd_ok = 1'b1; tick(DEB + HOLD - 1);
    check("R2", "inhibit one sample short", int'(inhibit), 1);
    cur_req = "R3";
    tick(1);
    check("R3", "inhibit after full sequence", int'(inhibit), 0);

    // R6: minimum low time
    cur_req = "R6"; base = pulses;
    strobe(1, 1'b0);
    strobe(MINL - 1, 1'b0);
    check("R6", "pulses for short strobes", pulses - base, 0);
    base = pulses;
    strobe(MINL, 1'b0);
    check("R6", "pulses for minimum strobe", pulses - base, 1);

    // R7: ending by chip select gives a single one-cycle pulse
    cur_req = "R7"; base = pulses;
    strobe(MINL, 1'b1);
    check("R7", "pulses ended by select", pulses - base, 1);

    // R11: long strobe yields one pulse
    cur_req = "R11"; base = pulses;
    strobe(12, 1'b0);
    check("R11", "pulses for long strobe", pulses - base, 1);

    // R5: incomplete command combinations
    cur_req = "R5"; base = pulses;
    ce_n = 1'b0; tick(5); ce_n = 1'b1; tick(2);
    we_n = 1'b0; tick(5); we_n = 1'b1; tick(2);
    oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; tick(5);
    ce_n = 1'b1; we_n = 1'b1; tick(1); oe_n = 1'b1; tick(3);
    check("R5", "pulses for non-write patterns", pulses - base, 0);

    // R8: output drive active at the ending sample
    cur_req = "R8"; base = pulses;
    ce_n = 1'b0; we_n = 1'b0; tick(4);
    oe_n = 1'b0; tick(1);
    ce_n = 1'b1; we_n = 1'b1; tick(1);
    oe_n = 1'b1; tick(3);
    check("R8", "pulses for aborted strobe", pulses - base, 0);

    // R9: supply dip inside a strobe
    cur_req = "R9"; base = pulses;
    ce_n = 1'b0; we_n = 1'b0; tick(2);
    vdd_ok = 1'b0; tick(1);
    vdd_ok = 1'b1; tick(3);
    we_n = 1'b1; tick(1); ce_n = 1'b1; tick(3);
    check("R9", "pulses with dip in strobe", pulses - base, 0);

    // R3: strobe during the hold-off
    cur_req = "R3"; base = pulses;
    strobe(5, 1'b0);
    check("R3", "pulses during hold-off", pulses - base, 0);

    // R4 / R10: restart of the whole supply sequence
    cur_req = "R4";
    vdd_ok = 1'b0; tick(1);
    check("R10", "inhibit after low sample", int'(inhibit), 1);
    vdd_ok = 1'b1; tick(DEB + HOLD - 1);
    check("R4", "inhibit before restart completes", int'(inhibit), 1);
    tick(1);
    check("R4", "inhibit after restart completes", int'(inhibit), 0);

    cur_req = "R10"; base = pulses;
    strobe(4, 1'b1);
    check("R10", "pulses once lockout ends", pulses - base, 1);

    tick(2);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule